// File: doc/BRIEF.md
# Iterative Integer Square Root Unit

This block computes the floor of the square root of a 16-bit unsigned operand over several clock cycles. It also produces the remainder, which is the operand minus the square of the root. A caller pulses `start_i` while the unit is idle and supplies the operand. The unit raises `busy_o` and works out one root bit per cycle. On completion it pulses `done_o` for one cycle and presents the results. Each iteration takes the next two operand bits, most significant pair first.

The unit also produces the side-effect values that the surrounding register context expects when the operation finishes. One scratch value is cleared to zero. A second value, sampled with the operand when the operation is accepted, is returned unchanged. The caller can write all four result values back together when `done_o` is high. The outputs keep their values until the next operation is accepted.

Top module: `isqrt_unit`

## Requirements
- R1: While the synchronous active-high reset is applied and on the first cycle after it, `busy_o` and `done_o` are 0 and `root_o`, `rem_o`, `clr_o` and `keep_o` are all zero.
- R2: A `start_i` pulse sampled at a rising edge while `busy_o` is 0 is accepted, and `busy_o` is 1 after that edge.
- R3: `done_o` goes high exactly 8 rising edges after the accepting edge and stays high for one cycle only. `busy_o` falls at the same edge that raises `done_o`.
- R4: When `done_o` is high, `root_o` is the largest integer r with r*r not above the accepted operand, zero-extended to 16 bits (it fits in the low 8 bits).
- R5: When `done_o` is high, `rem_o` equals the operand minus `root_o` squared. It is zero-extended and never exceeds 2*`root_o`.
- R6: When `done_o` is high, `clr_o` is zero.
- R7: When `done_o` is high, `keep_o` equals the `keep_i` value sampled at the accepting edge.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation neither restarts nor changes its operand, and its results and timing are those of the operand first accepted.
- R9: Corner operands: 0 gives root 0 and remainder 0. 1 gives root 1 and remainder 0. 65535 gives root 255 and remainder 510. 65025 gives root 255 and remainder 0.
- R10: While the unit is idle and no start is accepted, the result outputs stay unchanged from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, accepted only when idle |
| operand_i | input | 16 | Unsigned value whose root is computed |
| keep_i | input | 16 | Value returned unchanged with the results |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| root_o | output | 16 | Floor square root, zero-extended |
| rem_o | output | 16 | Operand minus root squared, zero-extended |
| clr_o | output | 16 | Scratch value, zero on completion |
| keep_o | output | 16 | Sampled `keep_i` value |

## Verification
Every result appears together with the `done_o` pulse, 8 rising edges after the edge that accepts the start. `busy_o` is high after the accepting edge and low again after the eighth. The bench drives inputs on falling edges and records, for each accepted operation, the edge count at which its `done_o` must appear. The bench then samples on falling edges and compares the root, remainder, cleared scratch and returned value in the first cycle in which `done_o` is seen. It rejects any pulse that comes on a different edge. Starts issued while busy add no expected entry. Any extra or restarted completion therefore shows up as a timing or value mismatch.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    localparam int DATA_W = 16;
    localparam int ROOT_W = DATA_W / 2;
    localparam int REM_W  = ROOT_W + 3;
    localparam int ITERS  = ROOT_W;
    localparam int CNT_W  = $clog2(ITERS);

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [ROOT_W-1:0] root;
        logic [REM_W-1:0]  rem;
    } sqrt_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] root;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] clr;
        logic [DATA_W-1:0] keep;
    } sqrt_result_t;

    function automatic sqrt_state_t sqrt_iter(input sqrt_state_t s);
        sqrt_state_t      n;
        logic [REM_W-1:0] pulled;
        logic [REM_W-1:0] trial;
        pulled = {s.rem[REM_W-3:0], s.src[DATA_W-1 -: 2]};
        trial  = {{(REM_W-ROOT_W-2){1'b0}}, s.root, 2'b01};
        n.src  = {s.src[DATA_W-3:0], 2'b00};
        if (pulled >= trial) begin
            n.rem  = pulled - trial;
            n.root = {s.root[ROOT_W-2:0], 1'b1};
        end else begin
            n.rem  = pulled;
            n.root = {s.root[ROOT_W-2:0], 1'b0};
        end
        return n;
    endfunction

endpackage

// File: rtl/isqrt_step.sv
module isqrt_step
    import isqrt_pkg::*;
(
    input  sqrt_state_t cur_i,
    output sqrt_state_t nxt_o
);
    always_comb begin
        nxt_o = sqrt_iter(cur_i);
    end
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
    import isqrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic last_o,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign accept_o = start_i && !busy_o;
    assign last_o   = busy_o && (cnt_q == CNT_W'(ITERS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_o <= last_o;
            if (accept_o) begin
                busy_o <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_o) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_o) begin
                    busy_o <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
    import isqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] keep_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] root_o,
    output logic [DATA_W-1:0] rem_o,
    output logic [DATA_W-1:0] clr_o,
    output logic [DATA_W-1:0] keep_o
);
    logic         accept;
    logic         last;
    sqrt_state_t  st_q;
    sqrt_state_t  st_nxt;
    sqrt_result_t res_q;
    logic [DATA_W-1:0] keep_q;

    isqrt_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .last_o   (last),
        .done_o   (done_o)
    );

    isqrt_step step_i (
        .cur_i (st_q),
        .nxt_o (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            keep_q <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                st_q.src  <= operand_i;
                st_q.root <= '0;
                st_q.rem  <= '0;
                keep_q    <= keep_i;
            end else if (busy_o) begin
                st_q <= st_nxt;
            end
            if (last) begin
                res_q.root <= DATA_W'(st_nxt.root);
                res_q.rem  <= DATA_W'(st_nxt.rem);
                res_q.clr  <= '0;
                res_q.keep <= keep_q;
            end
        end
    end

    assign root_o = res_q.root;
    assign rem_o  = res_q.rem;
    assign clr_o  = res_q.clr;
    assign keep_o = res_q.keep;
endmodule

// File: rtl/isqrt_unit_chk.sv
module isqrt_unit_chk
    import isqrt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] root_o,
    input logic [DATA_W-1:0] rem_o
);
    logic [DATA_W-1:0] op_q;
    logic [CNT_W+1:0]  age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            age_q <= '0;
        end else if (start_i && !busy_o) begin
            op_q  <= operand_i;
            age_q <= '0;
        end else if (busy_o) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R2
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R3
    p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (age_q == (CNT_W+2)'(ITERS)));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4, R5
    p_exact_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (32'(root_o) * 32'(root_o) + 32'(rem_o) == 32'(op_q)));

    p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (17'(rem_o) <= 17'(root_o) * 17'd2));

    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(root_o) && $stable(rem_o) && !done_o));
endmodule

bind isqrt_unit isqrt_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .operand_i (operand_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .root_o    (root_o),
    .rem_o     (rem_o)
);

// File: tb/isqrt_unit_tb_top.sv
module isqrt_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [15:0] keep_i = '0;
    logic        busy_o, done_o;
    logic [15:0] root_o, rem_o, clr_o, keep_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_seen = 0;
    logic [15:0] exp_root_q[$];
    logic [15:0] exp_rem_q[$];
    logic [15:0] exp_keep_q[$];
    int          exp_cyc_q[$];

    isqrt_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .operand_i(operand_i),
        .keep_i(keep_i), .busy_o(busy_o), .done_o(done_o), .root_o(root_o),
        .rem_o(rem_o), .clr_o(clr_o), .keep_o(keep_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_root(input int x);
        int r = 0;
        while ((r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    task automatic issue(input logic [15:0] x, input logic [15:0] k);
        int r;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        r = ref_root(int'(x));
        start_i   = 1'b1;
        operand_i = x;
        keep_i    = k;
        exp_root_q.push_back(16'(r));
        exp_rem_q.push_back(16'(int'(x) - r * r));
        exp_keep_q.push_back(k);
        exp_cyc_q.push_back(cyc + 1 + LATENCY);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after accept", 32'(busy_o), 32'd1);
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((exp_root_q.size() != 0 || busy_o) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // monitor: pops expected items on each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                done_seen++;
                if (exp_root_q.size() == 0) begin
                    check("R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    check("R3 done timing", 32'(cyc), 32'(exp_cyc_q.pop_front()));
                    check("R3 busy low at done", 32'(busy_o), 32'd0);
                    check("R4 root", 32'(root_o), 32'(exp_root_q.pop_front()));
                    check("R5 remainder", 32'(rem_o), 32'(exp_rem_q.pop_front()));
                    check("R6 clear output", 32'(clr_o), 32'd0);
                    check("R7 kept value", 32'(keep_o), 32'(exp_keep_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held_root;
        logic [15:0] held_rem;
        int seen_before;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy_o), 32'd0);
        check("R1 done in reset", 32'(done_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy_o), 32'd0);
        check("R1 root after reset", 32'(root_o), 32'd0);
        check("R1 rem after reset", 32'(rem_o), 32'd0);
        check("R1 keep after reset", 32'(keep_o), 32'd0);
        check("R1 clear after reset", 32'(clr_o), 32'd0);

        // R9 corners
        issue(16'd0, 16'h1111);     wait_drain();
        issue(16'd1, 16'h2222);     wait_drain();
        issue(16'd65535, 16'h3333); wait_drain();
        issue(16'd65025, 16'h4444); wait_drain();
        issue(16'd65024, 16'h5555); wait_drain();

        // R4 R5 assorted patterns, some back to back
        issue(16'd2, 16'h0001);
        issue(16'd99, 16'h0002);
        issue(16'd144, 16'h0003);
        issue(16'd4095, 16'h0004);
        issue(16'd4096, 16'hBEEF);
        issue(16'hAAAA, 16'h5555);
        issue(16'h5555, 16'hAAAA);
        wait_drain();

        // R8 start while busy is ignored
        seen_before = done_seen;
        issue(16'd50000, 16'h7777);
        @(negedge clk);
        start_i = 1'b1; operand_i = 16'd9; keep_i = 16'h0BAD;
        repeat (2) @(negedge clk);
        start_i = 1'b0; operand_i = 16'd0;
        wait_drain();
        repeat (12) @(negedge clk);
        check("R8 one completion only", 32'(done_seen - seen_before), 32'd1);

        // R10 results held while idle
        held_root = root_o;
        held_rem  = rem_o;
        operand_i = 16'd3;
        repeat (5) @(negedge clk);
        check("R10 root held", 32'(root_o), 32'(held_root));
        check("R10 rem held", 32'(rem_o), 32'(held_rem));
        check("R10 busy idle", 32'(busy_o), 32'd0);

        check("R3 all results seen", 32'(exp_root_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule